// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block is the device-side read data path of a double-data-rate SDRAM. It takes one decoded command per clock (read, write, burst stop, precharge) with a bank, a start column and an auto-precharge flag. After the selected CAS latency it drives two data words per clock, one for the high half and one for the low half of the clock, with a matching strobe. It also drives the strobe low for one cycle before the data and returns the data bus to high impedance after the last element.

A later read can cut a running burst short, or join onto its end, with no gap in the data stream. A burst stop or a write ends the stream one CAS latency after it is registered. A precharge to the bank being read does the same. Read data comes from a fixed pattern store addressed by bank and column. When a read with auto precharge runs to its natural end, the block pulses a precharge request for that bank.

The two data phases are modelled as a pair of registered words per clock (`dq_rise`, `dq_fall`) and a pair of strobe levels, with enables that stand for the output drivers.

Top module: `ddr_rd_burst_seq`

## Requirements
- R1: With `cl_sel`=0 the CAS latency is 2 clocks, and with `cl_sel`=1 it is 3 clocks. The first data pair of a read registered at clock edge k is on the outputs after edge k+CL.
- R2: Each data cycle carries two consecutive burst elements. Element 2p of the burst is on `dq_rise` and element 2p+1 is on `dq_fall`. In every data cycle the strobe reads `dqs_rise`=1 and `dqs_fall`=0 with `dqs_oe`=1.
- R3: In the cycle just before a burst that does not follow straight on from earlier data, `dqs_oe`=1 with both strobe levels 0 and `dq_oe`=0. This is the preamble.
- R4: The strobe enable drops together with the data enable, so the strobe is low during the last element. In the first cycle without data after a data cycle, `burst_done` pulses high for one cycle.
- R5: `dq_oe` is 0, meaning high impedance, in every cycle that carries no burst data, and both data words read 0 then.
- R6: `bl_sel` sets the burst length: 0 gives 2 elements, 1 gives 4, and 2 or 3 give 8. Columns advance by one and wrap inside the block of that length aligned on the start column.
- R7: The word stored at bank b, column c is `{c XOR 8'hC3, 6'b0, b}` (16-bit word, 8-bit column, 2-bit bank).
- R8: A read registered at edge j during a burst replaces all data from edge j+CL onward. Its first pair follows the last kept pair of the old burst with no gap and no preamble.
- R9: A burst stop (`cmd`=3) or a write (`cmd`=2) registered at edge j removes all data from edge j+CL onward.
- R10: A precharge (`cmd`=4) registered at edge j removes data from edge j+CL onward only if the pair driven after edge j+CL-1 belongs to the same bank. A precharge to another bank has no effect.
- R11: A read with `cmd_ap`=1 (`cmd`=1) that delivers its last pair without truncation pulses `ap_pre` for one cycle, with `ap_pre_bank` set to its bank, in the cycle after that last pair.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command: 0 none, 1 read, 2 write, 3 burst stop, 4 precharge |
| cmd_bank | input | 2 | Bank of the command |
| cmd_col | input | 8 | Start column of a read |
| cmd_ap | input | 1 | Auto precharge flag of a read |
| cl_sel | input | 1 | CAS latency select (0: 2, 1: 3) |
| bl_sel | input | 2 | Burst length select (0: 2, 1: 4, 2/3: 8) |
| dq_rise | output | 16 | Data word of the high clock phase |
| dq_fall | output | 16 | Data word of the low clock phase |
| dq_oe | output | 1 | Data driver enable |
| dqs_rise | output | 1 | Strobe level in the high phase |
| dqs_fall | output | 1 | Strobe level in the low phase |
| dqs_oe | output | 1 | Strobe driver enable |
| burst_done | output | 1 | One-cycle pulse when the stream ends |
| ap_pre | output | 1 | Auto-precharge request pulse |
| ap_pre_bank | output | 2 | Bank of the auto-precharge request |

## Verification
The assertions assume that `cl_sel` and `bl_sel` stay constant while any command is inside the latency window or any burst is still streaming. Under that assumption the strobe shape, the preamble-to-data step and the completion pulse follow from the command history. The stimulus changes either mode only after twelve idle cycles. Within a mode it issues any command in any cycle, including back-to-back reads and stops that land on the last pair of a burst. All such sequences are legal inputs for this block.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_BTERM = 3'd3,
        CMD_PRECH = 3'd4
    } cmd_e;

    // Burst length in elements for a length code
    function automatic int unsigned bl_elems(input logic [1:0] code);
        case (code)
            2'd0:    return 2;
            2'd1:    return 4;
            default: return 8;
        endcase
    endfunction

    // Burst length in clock cycles (element pairs)
    function automatic int unsigned bl_pairs(input logic [1:0] code);
        return bl_elems(code) / 2;
    endfunction

endpackage

// File: rtl/ddr_rd_cmd_pipe.sv
// Delay line for registered commands; the tap picks the stage for the CAS latency.
module ddr_rd_cmd_pipe #(
    parameter int REC_W = 16,
    parameter int DEPTH = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REC_W-1:0] in_rec,
    input  logic [SEL_W-1:0] tap_sel,
    output logic [REC_W-1:0] tap_rec
);
    logic [REC_W-1:0] stg_d [DEPTH];
    logic [REC_W-1:0] stg_q [DEPTH];

    always_comb begin
        stg_d[0] = in_rec;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign tap_rec = stg_q[tap_sel];

endmodule

// File: rtl/ddr_rd_col_gen.sv
// Column of one burst element: sequential, wrapping inside the aligned burst block.
module ddr_rd_col_gen #(
    parameter int COL_W = 8,
    parameter int IDX_W = 3
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [IDX_W-1:0] elem_idx,
    input  logic [1:0]       bl_code,
    output logic [COL_W-1:0] col_out
);
    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] stepped;

    always_comb begin
        wrap_mask = COL_W'(ddr_rd_pkg::bl_elems(bl_code) - 1);
        stepped   = start_col + COL_W'(elem_idx);
        col_out   = (start_col & ~wrap_mask) | (stepped & wrap_mask);
    end

endmodule

// File: rtl/ddr_rd_pattern_store.sv
// Fixed read content addressed by bank and column.
module ddr_rd_pattern_store #(
    parameter int               BANK_W  = 2,
    parameter int               COL_W   = 8,
    parameter int               DQ_W    = 16,
    parameter logic [COL_W-1:0] COL_XOR = 'hC3
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    output logic [DQ_W-1:0]   word
);
    localparam int COL_SHIFT = DQ_W - COL_W;

    always_comb begin
        word = (DQ_W'(col ^ COL_XOR) << COL_SHIFT) | DQ_W'(bank);
    end

endmodule

// File: rtl/ddr_rd_burst_seq.sv
module ddr_rd_burst_seq #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 8,
    parameter int DQ_W   = 16,
    parameter int MIN_CL = 2,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_ap,
    input  logic              cl_sel,
    input  logic [1:0]        bl_sel,
    output logic [DQ_W-1:0]   dq_rise,
    output logic [DQ_W-1:0]   dq_fall,
    output logic              dq_oe,
    output logic              dqs_rise,
    output logic              dqs_fall,
    output logic              dqs_oe,
    output logic              burst_done,
    output logic              ap_pre,
    output logic [BANK_W-1:0] ap_pre_bank
);
    import ddr_rd_pkg::*;

    localparam int PIPE_D = MAX_CL - 1;
    localparam int SEL_W  = (PIPE_D > 1) ? $clog2(PIPE_D) : 1;
    localparam int PAIR_W = 2;            // up to 4 pairs per burst
    localparam int IDX_W  = PAIR_W + 1;   // up to 8 elements
    localparam int LANES  = 2;            // high and low clock phase

    typedef struct packed {
        logic [2:0]        kind;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic [1:0]        bl;
    } rec_t;

    localparam int REC_W = $bits(rec_t);

    typedef struct packed {
        logic              pend_v;
        rec_t              pend;
        logic [BANK_W-1:0] cur_bank;
        logic [COL_W-1:0]  cur_col;
        logic              cur_ap;
        logic [1:0]        cur_bl;
        logic [PAIR_W-1:0] pair_idx;
        logic [PAIR_W-1:0] pairs_left;
        logic              ap_arm;
        logic [BANK_W-1:0] ap_bank;
        logic [DQ_W-1:0]   dq_r;
        logic [DQ_W-1:0]   dq_f;
        logic              dq_oe;
        logic              dqs_oe;
        logic              dqs_r;
        logic              dqs_f;
        logic              done;
        logic              pre_v;
        logic [BANK_W-1:0] pre_bank;
    } state_t;

    state_t st_d, st_q;

    // ---- command latency line ----
    rec_t             in_rec;
    logic [REC_W-1:0] tap_bits;
    rec_t             tap;
    logic [SEL_W-1:0] tap_sel;

    assign in_rec  = '{kind: cmd, bank: cmd_bank, col: cmd_col, ap: cmd_ap, bl: bl_sel};
    assign tap_sel = SEL_W'(cl_sel);
    assign tap     = rec_t'(tap_bits);

    ddr_rd_cmd_pipe #(.REC_W(REC_W), .DEPTH(PIPE_D), .SEL_W(SEL_W)) i_cmd_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_rec  (REC_W'(in_rec)),
        .tap_sel (tap_sel),
        .tap_rec (tap_bits)
    );

    // ---- pair selected for this edge ----
    logic              emit_v;
    logic              sel_pend;
    logic [BANK_W-1:0] emit_bank;
    logic [COL_W-1:0]  emit_col;
    logic [1:0]        emit_bl;
    logic              emit_ap;
    logic [PAIR_W-1:0] emit_pair;
    logic [LANES-1:0][DQ_W-1:0] lane_word;

    assign sel_pend  = st_q.pend_v;
    assign emit_v    = st_q.pend_v || (st_q.pairs_left != '0);
    assign emit_bank = sel_pend ? st_q.pend.bank : st_q.cur_bank;
    assign emit_col  = sel_pend ? st_q.pend.col  : st_q.cur_col;
    assign emit_bl   = sel_pend ? st_q.pend.bl   : st_q.cur_bl;
    assign emit_ap   = sel_pend ? st_q.pend.ap   : st_q.cur_ap;
    assign emit_pair = sel_pend ? '0 : st_q.pair_idx + 1'b1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [COL_W-1:0] lane_col;

        ddr_rd_col_gen #(.COL_W(COL_W), .IDX_W(IDX_W)) i_col_gen (
            .start_col (emit_col),
            .elem_idx  ({emit_pair, 1'(g)}),
            .bl_code   (emit_bl),
            .col_out   (lane_col)
        );

        ddr_rd_pattern_store #(.BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W)) i_store (
            .bank (emit_bank),
            .col  (lane_col),
            .word (lane_word[g])
        );
    end

    // ---- stop conditions seen at the latency tap ----
    logic stop_hit;
    logic [PAIR_W-1:0] left_after;

    assign stop_hit = (tap.kind == CMD_BTERM) || (tap.kind == CMD_WRITE) ||
                      ((tap.kind == CMD_PRECH) && emit_v && (tap.bank == emit_bank));
    assign left_after = sel_pend ? PAIR_W'(bl_pairs(emit_bl) - 1) : st_q.pairs_left - 1'b1;

    always_comb begin
        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.ap_arm   = 1'b0;
        st_d.pre_v    = st_q.ap_arm;
        st_d.pre_bank = st_q.ap_arm ? st_q.ap_bank : '0;
        st_d.dq_oe    = emit_v;
        st_d.dqs_oe   = emit_v;
        st_d.dqs_r    = emit_v;
        st_d.dqs_f    = 1'b0;
        st_d.dq_r     = emit_v ? lane_word[0] : '0;
        st_d.dq_f     = emit_v ? lane_word[1] : '0;

        if (emit_v) begin
            st_d.pend_v     = 1'b0;
            st_d.cur_bank   = emit_bank;
            st_d.cur_col    = emit_col;
            st_d.cur_bl     = emit_bl;
            st_d.cur_ap     = emit_ap;
            st_d.pair_idx   = emit_pair;
            st_d.pairs_left = left_after;
            if ((left_after == '0) && emit_ap) begin
                st_d.ap_arm  = 1'b1;
                st_d.ap_bank = emit_bank;
            end
        end else begin
            st_d.done = st_q.dq_oe;
        end

        if (stop_hit) begin
            st_d.pairs_left = '0;
        end

        if (tap.kind == CMD_READ) begin
            st_d.pend_v = 1'b1;
            st_d.pend   = tap;
            if (!emit_v) begin
                st_d.dqs_oe = 1'b1;   // preamble: strobe driven low
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_rise     = st_q.dq_r;
    assign dq_fall     = st_q.dq_f;
    assign dq_oe       = st_q.dq_oe;
    assign dqs_rise    = st_q.dqs_r;
    assign dqs_fall    = st_q.dqs_f;
    assign dqs_oe      = st_q.dqs_oe;
    assign burst_done  = st_q.done;
    assign ap_pre      = st_q.pre_v;
    assign ap_pre_bank = st_q.pre_bank;

    // ---- assertions ----
    a_r2_strobe_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (dqs_oe && dqs_rise && !dqs_fall));

    a_r3_preamble_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        (dqs_oe && !dq_oe) |=> dq_oe);

    a_r3_preamble_low: assert property (@(posedge clk) disable iff (!rst_n)
        (dqs_oe && !dq_oe) |-> (!dqs_rise && !dqs_fall));

    a_r4_done_on_stream_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> burst_done);

    a_r4_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    a_r11_pre_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        ap_pre |-> $past(dq_oe));

endmodule

// File: tb/test_ddr_rd_burst_seq.sv
`timescale 1ns/1ps
module test_ddr_rd_burst_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [1:0]  cmd_bank = 2'd0;
    logic [7:0]  cmd_col = 8'd0;
    logic        cmd_ap = 1'b0;
    logic        cl_sel = 1'b0;
    logic [1:0]  bl_sel = 2'd1;
    logic [15:0] dq_rise, dq_fall;
    logic        dq_oe, dqs_rise, dqs_fall, dqs_oe, burst_done, ap_pre;
    logic [1:0]  ap_pre_bank;

    always #10 clk = ~clk;   // 50 MHz

    ddr_rd_burst_seq i_ddr_rd_burst_seq (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .cmd_ap(cmd_ap), .cl_sel(cl_sel), .bl_sel(bl_sel),
        .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe), .dqs_rise(dqs_rise),
        .dqs_fall(dqs_fall), .dqs_oe(dqs_oe), .burst_done(burst_done),
        .ap_pre(ap_pre), .ap_pre_bank(ap_pre_bank)
    );

    int edge_n = 0;
    always @(posedge clk) edge_n <= edge_n + 1;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string scen = "R12";

    // Reference timeline, one slot per clock edge
    bit          m_oe    [8192];
    logic [15:0] m_r     [8192];
    logic [15:0] m_f     [8192];
    int          m_bank  [8192];
    bit          m_apend [8192];

    function automatic logic [15:0] exp_word(int b, int c);
        logic [7:0] cc;
        cc = 8'(c) ^ 8'hC3;
        return {cc, 6'b000000, 2'(b)};
    endfunction

    function automatic int elem_col(int start, int i, int bl);
        int base;
        base = start - (start % bl);
        return base + ((start % bl) + i) % bl;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (scenario %s) edge %0d: actual %h expected %h",
                     req, scen, edge_n, act, exp);
        end
    endtask

    task automatic compare();
        int t;
        bit eo, nx, pv, ap_e;
        logic [31:0] exp_d;
        logic [2:0]  exp_s;
        int pb;
        t    = edge_n;
        eo   = m_oe[t];
        nx   = m_oe[t+1];
        pv   = (t > 0) ? m_oe[t-1] : 1'b0;
        ap_e = (t > 0) ? m_apend[t-1] : 1'b0;
        pb   = (t > 0 && ap_e) ? m_bank[t-1] : 0;
        exp_d = eo ? {m_r[t], m_f[t]} : 32'h0;
        exp_s = {eo | nx, eo, 1'b0};
        chk(dq_oe == eo, "R5", 32'(dq_oe), 32'(eo));
        chk({dq_rise, dq_fall} == exp_d, "R2,R7", {dq_rise, dq_fall}, exp_d);
        chk({dqs_oe, dqs_rise, dqs_fall} == exp_s, "R3", 32'({dqs_oe, dqs_rise, dqs_fall}), 32'(exp_s));
        chk(burst_done == (pv && !eo), "R4", 32'(burst_done), 32'(pv && !eo));
        chk({ap_pre, ap_pre_bank} == {ap_e, 2'(pb)}, "R11", 32'({ap_pre, ap_pre_bank}), 32'({ap_e, 2'(pb)}));
    endtask

    task automatic clear_from(int s0);
        for (int s = s0; s < s0 + 12; s++) begin
            m_oe[s] = 1'b0;
            m_apend[s] = 1'b0;
        end
    endtask

    task automatic model_cmd(int kind, int b, int c, bit ap);
        int k, cl, bl, np;
        k  = edge_n + 1;
        cl = cl_sel ? 3 : 2;
        bl = (bl_sel == 2'd0) ? 2 : (bl_sel == 2'd1) ? 4 : 8;
        np = bl / 2;
        if (kind == 1) begin
            clear_from(k + cl);
            for (int p = 0; p < np; p++) begin
                m_oe[k+cl+p]    = 1'b1;
                m_r[k+cl+p]     = exp_word(b, elem_col(c, 2*p, bl));
                m_f[k+cl+p]     = exp_word(b, elem_col(c, 2*p+1, bl));
                m_bank[k+cl+p]  = b;
                m_apend[k+cl+p] = ap && (p == np - 1);
            end
        end else if (kind == 2 || kind == 3) begin
            clear_from(k + cl);
        end else if (kind == 4) begin
            if (m_oe[k+cl-1] && m_bank[k+cl-1] == b) clear_from(k + cl);
        end
    endtask

    task automatic step(int kind = 0, int b = 0, int c = 0, bit ap = 1'b0);
        @(negedge clk);
        compare();
        cmd      = 3'(kind);
        cmd_bank = 2'(b);
        cmd_col  = 8'(c);
        cmd_ap   = ap;
        model_cmd(kind, b, c, ap);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_mode(bit cl, int bl);
        idle(12);
        cl_sel = cl;
        bl_sel = 2'(bl);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    initial begin
        #(20.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R12: outputs held at zero in reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk({dq_rise, dq_fall} == 32'h0, "R12", {dq_rise, dq_fall}, 32'h0);
            chk({dq_oe, dqs_rise, dqs_fall, dqs_oe, burst_done, ap_pre, ap_pre_bank} == 8'h0, "R12",
                32'({dq_oe, dqs_rise, dqs_fall, dqs_oe, burst_done, ap_pre, ap_pre_bank}), 32'h0);
        end
        rst_n = 1'b1;

        // R1 R6: CL2 BL4, start column wraps inside its 4-block
        scen = "R1,R6";
        set_mode(1'b0, 1); step(1, 1, 5); idle(10);
        // R1 R6: CL3 BL8 with wrap
        set_mode(1'b1, 2); step(1, 2, 14); idle(12);
        set_mode(1'b1, 0); step(1, 3, 200); idle(8);
        set_mode(1'b0, 3); step(1, 0, 0); idle(10);

        // R8: concatenation and truncation
        scen = "R8";
        set_mode(1'b0, 1); step(1, 1, 8); step(); step(1, 2, 33); idle(10);
        set_mode(1'b1, 2); step(1, 0, 16); step(1, 3, 7); idle(12);
        set_mode(1'b1, 2); step(1, 0, 16); step(); step(); step(1, 1, 90); idle(12);

        // R9: burst stop and write
        scen = "R9";
        set_mode(1'b1, 2); step(1, 2, 40); step(); step(3); idle(12);
        set_mode(1'b0, 2); step(1, 1, 41); step(2); idle(12);

        // R10: precharge same bank truncates, other bank ignored
        scen = "R10";
        set_mode(1'b0, 2); step(1, 2, 60); step(); step(4, 2); idle(12);
        set_mode(1'b0, 2); step(1, 2, 60); step(); step(4, 1); idle(12);

        // R11: auto precharge at natural end, suppressed when truncated
        scen = "R11";
        set_mode(1'b0, 1); step(1, 3, 3, 1'b1); idle(10);
        set_mode(1'b1, 0); step(1, 1, 9, 1'b1); step(1, 2, 10, 1'b1); idle(10);
        set_mode(1'b0, 2); step(1, 1, 12, 1'b1); step(1, 0, 1); idle(12);

        // Mixed command streams per mode
        scen = "R1,R6,R8,R9,R10,R11";
        for (int seg = 0; seg < 4; seg++) begin
            set_mode(seg[0], seg % 3);
            for (int i = 0; i < 250; i++) begin
                int r;
                r = $urandom % 10;
                if (r < 4)       step();
                else if (r < 7)  step(1, $urandom % 4, $urandom % 256, ($urandom % 4) == 0);
                else if (r == 7) step(3);
                else if (r == 8) step(2);
                else             step(4, $urandom % 4);
            end
        end
        idle(12);

        summary();
        $finish;
    end

endmodule